// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block multiplies two multi-word integers modulo an odd modulus and returns the result in Montgomery form: for operands `a`, `b` and modulus `n`, each `s` words of `W` bits, it produces a value congruent to `a·b·2^-(W·s)` mod `n` and smaller than `2n`. The outer loop of the coarsely integrated operand scanning method (one word `b_i` per pass) is spread over a chain of `P` processing elements. A single stream of words circulates around the chain. Each element runs one outer pass, and the next element starts its pass as soon as the first word of the previous pass appears. An element that finishes a pass picks up the next one that has not started, so passes go round the ring.

Only the head of the chain reads the operand memories. Each word `j` of `a`, `n` and `b` is fetched once, through one shared address bus with synchronous memories of one-cycle latency. The stream token carries `a_j`, `n_j` and the partial-sum word down the chain. It also carries a `b` word, which moves one position forward on every pass, so each element finds its own `b_i` in the first token it receives. Only the tail of the chain writes the result, one word per cycle, into an external result memory.

Between elements the stream uses valid/ready. A token moves only when the sender's output register is full and the receiver can take it. Each element refuses input for one cycle after the last word of a pass, while it emits the top word of that pass. FIFOs between elements, and one on the return path into the head, absorb these stalls. They also hold the returning head of the stream while the head element is still working through the tail of its previous pass. The control pins stay plain: `start` is a level sampled when idle, and `done` is a single-cycle pulse.

Top module: `mont_cios_mul`

## Requirements
- R1: After reset, `done`, `rd_en` and `res_we` are low.
- R2: The result word count is `s+1`. The value assembled from result addresses 0..s (address 0 is least significant) is below `2n`. Multiplied by `2^(W·s)`, it is congruent to `a·b` mod `n`.
- R3: When a start is accepted, `rd_en` is high for exactly `s` consecutive cycles, beginning in the next cycle, with `rd_addr` stepping 0, 1, …, s-1.
- R4: `done` is high for exactly one cycle. That cycle immediately follows the cycle in which address `s` is written.
- R5: While an operation is in progress, `start` is ignored, and `nwords` and `n0_inv` presented with it have no effect on the reads or on the result.
- R6: `nwords` and `n0_inv` are captured when start is accepted, and any `s` from 2 to `SMAX` works.
- R7: Result words are written one per write cycle in ascending address order, 0 through `s`.
- R8: The corner operands `a = 0` (result congruent to 0) and `a = b = n-1` give correct results.
- R9: No operand read takes place in a cycle in which a result word is written.
- R10: A start presented in the same cycle as `done` is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| nwords | input | $clog2(SMAX+1) | Operand word count s |
| n0_inv | input | W | -n0^-1 mod 2^W |
| rd_en | output | 1 | Read strobe to the a, b and n memories |
| rd_addr | output | $clog2(SMAX+1) | Word address for all three memories |
| a_rdata | input | W | Word of a, one cycle after rd_en |
| b_rdata | input | W | Word of b, one cycle after rd_en |
| n_rdata | input | W | Word of n, one cycle after rd_en |
| res_we | output | 1 | Result memory write enable |
| res_addr | output | $clog2(SMAX+1) | Result word address |
| res_wdata | output | W | Result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can coincide with the end of an operation: the `done` pulse and a fresh `start`. The bench provokes this by raising `start` for the next operation in the very cycle `done` is seen. The old result must already be complete in the result memory, and the new read burst must begin one cycle later and count exactly `s` reads. Inside the ring, the head element can be finishing the tail of one pass while the returning head of the stream arrives. Runs at `s = 8` with two elements force this, and they are judged only by the congruence and bound of the final value.

// File: rtl/mont_cios_pkg.sv
package mont_cios_pkg;

  // Control phases of the multiplier.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } ctl_state_e;

  // Default geometry.
  localparam int unsigned DEF_W    = 16;
  localparam int unsigned DEF_SMAX = 8;
  localparam int unsigned DEF_P    = 2;

endpackage

// File: rtl/mont_word_fifo.sv
module mont_word_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mont_cios_pe.sv
module mont_cios_pe #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 4,
  parameter int unsigned TW = 4*W + IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] s_lim,
  input  logic [W-1:0]  n0p,
  input  logic          in_vld,
  input  logic [TW-1:0] in_tok,
  output logic          in_rdy,
  output logic          out_vld,
  output logic [TW-1:0] out_tok,
  input  logic          out_rdy
);
  localparam int unsigned DW = 2*W;

  typedef struct packed {
    logic [W-1:0]  a;
    logic [W-1:0]  n;
    logic [W-1:0]  t;
    logic [W-1:0]  bw;
    logic [IW-1:0] it;
    logic          fst;
    logic          lst;
  } tok_t;

  tok_t in_t, ot, nxt;
  assign in_t    = in_tok;
  assign out_tok = ot;

  logic          ovld, pend, sec;
  logic [W-1:0]  cb_q, cr_q, b_q, m_q, ha, hn, ptop;
  logic [IW-1:0] pit;

  logic          pass, out_free, acc, load;
  logic [W-1:0]  bsel, msel, mnew, top;
  logic [DW-1:0] u, v;

  assign pass     = (in_t.it == s_lim);
  assign out_free = !ovld || out_rdy;
  assign in_rdy   = !pend && out_free;
  assign acc      = in_vld && in_rdy;
  assign load     = pend ? out_free : (acc && (pass || !in_t.fst));
  assign out_vld  = ovld;

  always_comb begin
    bsel = in_t.fst ? in_t.bw : b_q;
    u    = DW'(in_t.t) + DW'(in_t.a) * DW'(bsel)
         + DW'(in_t.fst ? {W{1'b0}} : cb_q);
    mnew = u[W-1:0] * n0p;
    msel = in_t.fst ? mnew : m_q;
    v    = DW'(u[W-1:0]) + DW'(in_t.n) * DW'(msel)
         + DW'(in_t.fst ? {W{1'b0}} : cr_q);
    top  = u[DW-1:W] + v[DW-1:W];

    if (pend) begin
      nxt = '{a: '0, n: '0, t: ptop, bw: '0, it: pit, fst: 1'b0, lst: 1'b1};
    end else if (pass) begin
      nxt = in_t;
    end else begin
      nxt = '{a: ha, n: hn, t: v[W-1:0], bw: in_t.bw,
              it: in_t.it + IW'(1), fst: sec, lst: 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovld <= 1'b0;
      pend <= 1'b0;
      sec  <= 1'b0;
      ot   <= '0;
      cb_q <= '0;
      cr_q <= '0;
      b_q  <= '0;
      m_q  <= '0;
      ha   <= '0;
      hn   <= '0;
      ptop <= '0;
      pit  <= '0;
    end else begin
      if (load) begin
        ovld <= 1'b1;
        ot   <= nxt;
      end else if (out_rdy) begin
        ovld <= 1'b0;
      end
      if (pend && out_free) pend <= 1'b0;
      if (acc && !pass) begin
        cb_q <= u[DW-1:W];
        cr_q <= v[DW-1:W];
        ha   <= in_t.a;
        hn   <= in_t.n;
        sec  <= in_t.fst;
        if (in_t.fst) begin
          b_q <= in_t.bw;
          m_q <= mnew;
        end
        if (in_t.lst) begin
          pend <= 1'b1;
          ptop <= top;
          pit  <= in_t.it + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mont_cios_mul.sv
module mont_cios_mul
  import mont_cios_pkg::*;
#(
  parameter int unsigned W    = DEF_W,
  parameter int unsigned SMAX = DEF_SMAX,
  parameter int unsigned P    = DEF_P,
  localparam int unsigned IW  = $clog2(SMAX+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] nwords,
  input  logic [W-1:0]  n0_inv,
  output logic          rd_en,
  output logic [IW-1:0] rd_addr,
  input  logic [W-1:0]  a_rdata,
  input  logic [W-1:0]  b_rdata,
  input  logic [W-1:0]  n_rdata,
  output logic          res_we,
  output logic [IW-1:0] res_addr,
  output logic [W-1:0]  res_wdata,
  output logic          done
);
  localparam int unsigned TW    = 4*W + IW + 2;
  localparam int unsigned FD    = 2**$clog2(SMAX + P + 2);
  localparam int unsigned O_LST = 0;
  localparam int unsigned O_FST = 1;
  localparam int unsigned O_IT  = 2;
  localparam int unsigned O_T   = 2 + IW + W;

  ctl_state_e    st;
  logic [IW-1:0] s_q, fcnt, rd_j, ra;
  logic [W-1:0]  n0p_q;
  logic          rd_pend, pad_pend, use_feed, done_q;

  // ring wiring
  logic          pe_in_vld  [P];
  logic [TW-1:0] pe_in_tok  [P];
  logic          pe_in_rdy  [P];
  logic          pe_out_vld [P];
  logic [TW-1:0] pe_out_tok [P];
  logic          pe_out_rdy [P];

  // head feeder FIFO
  logic          feed_push, feed_pop, feed_full, feed_empty;
  logic [TW-1:0] feed_wtok, feed_rtok;

  // return path FIFO
  logic          fb_push, fb_pop, fb_full, fb_empty;
  logic [TW-1:0] fb_rtok;

  logic          tail_final, tail_lst;

  assign rd_en   = (st == ST_FETCH);
  assign rd_addr = fcnt;
  assign done    = done_q;

  // ---------------- feeder ----------------
  assign feed_push = rd_pend || pad_pend;
  assign feed_wtok = rd_pend
    ? {a_rdata, n_rdata, {W{1'b0}}, b_rdata, {IW{1'b0}}, (rd_j == '0), 1'b0}
    : {{(4*W+IW+1){1'b0}}, 1'b1};

  mont_word_fifo #(.DW(TW), .DEPTH(FD)) u_feed (
    .clk(clk), .rst_n(rst_n),
    .push(feed_push), .wdata(feed_wtok),
    .pop(feed_pop), .rdata(feed_rtok),
    .full(feed_full), .empty(feed_empty)
  );

  // ---------------- head input select ----------------
  assign pe_in_vld[0] = use_feed ? !feed_empty : !fb_empty;
  assign pe_in_tok[0] = use_feed ? feed_rtok : fb_rtok;
  assign feed_pop     = use_feed && pe_in_vld[0] && pe_in_rdy[0];
  assign fb_pop       = !use_feed && pe_in_vld[0] && pe_in_rdy[0];

  // ---------------- PE chain ----------------
  for (genvar k = 0; k < P; k++) begin : g_pe
    mont_cios_pe #(.W(W), .IW(IW), .TW(TW)) u_pe (
      .clk(clk), .rst_n(rst_n),
      .s_lim(s_q), .n0p(n0p_q),
      .in_vld(pe_in_vld[k]), .in_tok(pe_in_tok[k]), .in_rdy(pe_in_rdy[k]),
      .out_vld(pe_out_vld[k]), .out_tok(pe_out_tok[k]), .out_rdy(pe_out_rdy[k])
    );
  end

  for (genvar k = 1; k < P; k++) begin : g_link
    logic link_full, link_empty;
    mont_word_fifo #(.DW(TW), .DEPTH(FD)) u_link (
      .clk(clk), .rst_n(rst_n),
      .push(pe_out_vld[k-1] && !link_full), .wdata(pe_out_tok[k-1]),
      .pop(pe_in_vld[k] && pe_in_rdy[k]), .rdata(pe_in_tok[k]),
      .full(link_full), .empty(link_empty)
    );
    assign pe_out_rdy[k-1] = !link_full;
    assign pe_in_vld[k]    = !link_empty;
  end

  // ---------------- tail: result or return ----------------
  assign tail_final    = (pe_out_tok[P-1][O_IT +: IW] == s_q);
  assign tail_lst      = pe_out_tok[P-1][O_LST];
  assign pe_out_rdy[P-1] = tail_final ? 1'b1 : !fb_full;
  assign fb_push       = pe_out_vld[P-1] && !tail_final && !fb_full;

  mont_word_fifo #(.DW(TW), .DEPTH(FD)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .push(fb_push), .wdata(pe_out_tok[P-1]),
    .pop(fb_pop), .rdata(fb_rtok),
    .full(fb_full), .empty(fb_empty)
  );

  assign res_we    = pe_out_vld[P-1] && tail_final;
  assign res_addr  = ra;
  assign res_wdata = pe_out_tok[P-1][O_T +: W];

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      s_q      <= '0;
      n0p_q    <= '0;
      fcnt     <= '0;
      rd_j     <= '0;
      rd_pend  <= 1'b0;
      pad_pend <= 1'b0;
      use_feed <= 1'b0;
      ra       <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      rd_pend  <= (st == ST_FETCH);
      rd_j     <= fcnt;
      pad_pend <= rd_pend && (rd_j == s_q - IW'(1));
      if (res_we) ra <= ra + IW'(1);
      if (feed_pop && feed_rtok[O_LST]) use_feed <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_FETCH;
            s_q      <= nwords;
            n0p_q    <= n0_inv;
            fcnt     <= '0;
            ra       <= '0;
            use_feed <= 1'b1;
          end
        end
        ST_FETCH: begin
          fcnt <= fcnt + IW'(1);
          if (fcnt == s_q - IW'(1)) st <= ST_RUN;
        end
        ST_RUN: begin
          if (res_we && tail_lst) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // feed_full and the inner element flags are sized out of reach by FD
  logic unused_ok;
  assign unused_ok = feed_full ^ pe_out_tok[P-1][O_FST];
endmodule

// File: rtl/mont_cios_chk.sv
module mont_cios_chk #(
  parameter int unsigned IW   = 4,
  parameter int unsigned SMAX = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_en,
  input logic          res_we,
  input logic [IW-1:0] res_addr,
  input logic          done
);
  // R4: completion is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: completion directly follows a result write
  a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_we));

  // R3: a read burst only begins right after a start request
  a_r3_reads_follow_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> $past(start));

  // R9: operand reads and result writes never share a cycle
  a_r9_no_read_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !rd_en);

  // R2: result addresses stay within the s+1 word window
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_addr <= IW'(SMAX)));
endmodule

bind mont_cios_mul mont_cios_chk #(.IW(IW), .SMAX(SMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
  .res_we(res_we), .res_addr(res_addr), .done(done)
);

// File: tb/mont_cios_mul_tb_top.sv
module mont_cios_mul_tb_top;
  localparam int unsigned W    = 16;
  localparam int unsigned SMAX = 8;
  localparam int unsigned P    = 2;
  localparam int unsigned IW   = $clog2(SMAX+1);
  localparam int unsigned BW   = 2*W*SMAX + 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] nwords = '0;
  logic [W-1:0]  n0_inv = '0;
  logic          rd_en, res_we, done;
  logic [IW-1:0] rd_addr, res_addr;
  logic [W-1:0]  a_rdata, b_rdata, n_rdata, res_wdata;

  always #2 clk = ~clk;

  mont_cios_mul #(.W(W), .SMAX(SMAX), .P(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nwords(nwords), .n0_inv(n0_inv),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .a_rdata(a_rdata), .b_rdata(b_rdata), .n_rdata(n_rdata),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata), .done(done)
  );

  // memory models
  logic [W-1:0] amem [SMAX];
  logic [W-1:0] bmem [SMAX];
  logic [W-1:0] nmem [SMAX];
  logic [W-1:0] rmem [SMAX+1];

  always @(posedge clk) begin
    if (rd_en) begin
      a_rdata <= amem[rd_addr];
      b_rdata <= bmem[rd_addr];
      n_rdata <= nmem[rd_addr];
    end
    if (res_we) rmem[res_addr] <= res_wdata;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed {
    logic [BW-1:0] abm;
    logic [BW-1:0] nv;
    logic [7:0]    sw;
  } exp_t;
  exp_t sb[$];
  int   ops_done = 0;

  int   rd_cnt = 0, wr_cnt = 0;
  bit   rd_bad = 0, wr_bad = 0, prev_we = 0, prev_done = 0;
  logic [IW-1:0] prev_we_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done)
        chk(!done, "R4 done width", BW'(done), BW'(0));
      if (rd_en) begin
        if (rd_addr != IW'(rd_cnt)) rd_bad = 1;
        rd_cnt++;
      end
      if (res_we) begin
        if (res_addr != IW'(wr_cnt)) wr_bad = 1;
        wr_cnt++;
      end
      if (done) begin
        exp_t e;
        logic [BW-1:0] r;
        e = sb.pop_front();
        r = '0;
        for (int k = SMAX; k >= 0; k--)
          if (k <= int'(e.sw)) r = (r << W) | BW'(rmem[k]);
        chk(r < (e.nv << 1), "R2 bound", r, e.nv << 1);
        chk(((r << (W*e.sw)) % e.nv) == e.abm, "R2 R6 R8 congruence",
            (r << (W*e.sw)) % e.nv, e.abm);
        chk(!rd_bad && rd_cnt == int'(e.sw), "R3 R5 read burst",
            BW'(rd_cnt), BW'(e.sw));
        chk(!wr_bad && wr_cnt == int'(e.sw) + 1, "R7 write order",
            BW'(wr_cnt), BW'(e.sw + 1));
        chk(prev_we && prev_we_addr == IW'(e.sw), "R4 done timing",
            BW'(prev_we_addr), BW'(e.sw));
        rd_cnt = 0; wr_cnt = 0; rd_bad = 0; wr_bad = 0;
        ops_done++;
      end
      prev_we      = res_we;
      prev_we_addr = res_addr;
      prev_done    = done;
    end
  end

  function automatic logic [W-1:0] neg_inv(input logic [W-1:0] n0);
    logic [31:0] x;
    x = 32'(n0);
    for (int i = 0; i < 5; i++)
      x = (x * (32'd2 - 32'(n0) * x)) & ((32'd1 << W) - 1);
    return W'(-x);
  endfunction

  function automatic logic [BW-1:0] rand_wide(input int sw);
    logic [BW-1:0] v = '0;
    for (int k = 0; k < sw; k++) v = (v << W) | BW'($urandom_range(0, (1<<W)-1));
    return v;
  endfunction

  // driver: mode 0 random, 1 a=0, 2 a=b=n-1; extra start mid-run; b2b skip wait-before
  task automatic run_op(input int sw, input int mode, input bit extra);
    logic [BW-1:0] nv, av, bv;
    exp_t e;
    nv = rand_wide(sw) | (BW'(1) << (W*sw - 1)) | BW'(1);
    av = rand_wide(sw) % nv;
    bv = rand_wide(sw) % nv;
    if (mode == 1) av = '0;
    if (mode == 2) begin av = nv - 1; bv = nv - 1; end
    for (int k = 0; k < SMAX; k++) begin
      amem[k] = W'(av >> (W*k));
      bmem[k] = W'(bv >> (W*k));
      nmem[k] = W'(nv >> (W*k));
    end
    e.abm = (av * bv) % nv;
    e.nv  = nv;
    e.sw  = 8'(sw);
    sb.push_back(e);
    start  = 1'b1;
    nwords = IW'(sw);
    n0_inv = neg_inv(W'(nv));
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start  = 1'b1;            // R5: must be ignored
      nwords = IW'(2);
      n0_inv = W'($urandom);
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
  endtask

  initial begin
    for (int k = 0; k <= SMAX; k++) rmem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!done && !rd_en && !res_we, "R1 reset outputs",
        BW'({done, rd_en, res_we}), BW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    run_op(4, 0, 0);
    run_op(4, 0, 0);            // R10: issued in the done cycle
    run_op(4, 1, 0);
    run_op(4, 2, 0);
    run_op(2, 0, 0);
    run_op(3, 0, 0);
    run_op(8, 0, 0);
    run_op(8, 2, 0);
    run_op(4, 0, 1);
    run_op(8, 0, 1);
    repeat (4) @(negedge clk);
    chk(ops_done == 10 && sb.size() == 0, "R10 all operations completed",
        BW'(ops_done), BW'(10));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=10", ops_done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule